// File: doc/BRIEF.md
# SPI Master FIFO Transfer Engine

This block is a full-duplex SPI master. Words are queued in an 8-entry transmit FIFO, and each entry carries an end-of-transfer tag. Received words collect in an 8-entry receive FIFO. A start strobe sets the engine running. It shifts word after word until it has sent a word whose tag is set, and then it raises a done event.

Word length, clock polarity, clock phase, bit order and a two-level clock divider are captured from configuration inputs only while the device is disabled. Nine sticky events each have a mask bit. The unmasked events are combined into a single interrupt. If the transmit FIFO runs dry before a tagged word has been sent, the engine pauses, and a fresh start strobe resumes it.

Top module: `spim_engine`

## Requirements
- R1: After reset, `evt_o` is 0, `irq_o` is 0, `rx_empty_o` is 1, `tx_full_o` is 0, `ready_o` is 0, `sclk_o` is 0 and `clr_busy_o` is 0.
- R2: `ready_o` follows `en_i` one cycle late. The configuration inputs are captured only while `en_i` is low, and changes made while it is high have no effect on transfers. A start strobe is accepted only while `ready_o` is 1.
- R3: The word length is `cfg_len_i` bits, from 4 to 24 (values outside that range saturate). Words are right-aligned in both FIFOs: transmit bits above the length are not sent, and receive bits above the length read 0.
- R4: With `cfg_lsb_i`=1 bit 0 is shifted first; with 0 bit (length-1) is shifted first.
- R5: `sclk_o` idles at `cfg_cpol_i`. With `cfg_cdly_i`=1, data is valid before the first edge and is sampled on the edge leaving idle. With 0, data changes on the leading edge and is sampled on the trailing edge.
- R6: Each half period of `sclk_o` lasts (2<<`cfg_div_i`)*(`cfg_brg_i`+1) clock cycles.
- R7: When a word pushed with `tx_last_i`=1 has been shifted, event bit 0 (done) is set and the engine goes idle with `sclk_o` at idle level.
- R8: If the engine needs a word and the TX FIFO is empty, it stops with the clock idle and sets event bit 3 (TX underflow). A later start strobe resumes the transfer. A start strobe with an empty TX FIFO does the same.
- R9: Event bits are 0 done, 1 slave done (never set by this master), 2 multi-master error (set by `mm_err_i`), 3 TX underflow, 4 TX overflow, 5 TX request (a word taken from the TX FIFO), 6 RX underflow, 7 RX overflow and 8 RX request (a word stored). Events are sticky and are cleared by writing 1 on `evt_clr_i`. A set in the same cycle wins.
- R10: `irq_o` is 1 exactly when some event is pending whose `evt_msk_i` bit is 0.
- R11: A push into a full TX FIFO is dropped and sets bit 4. A received word arriving at a full RX FIFO is dropped and sets bit 7. A pop from an empty RX FIFO sets bit 6.
- R12: A pulse on `rx_clr_i` or `tx_clr_i` raises `clr_busy_o` bit 0 or bit 1 respectively for one cycle, and then the FIFO is empty.
- R13: `rx_empty_o` reports an empty RX FIFO and `tx_full_o` a TX FIFO holding 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Device enable; configuration is captured while low |
| cfg_len_i | input | 5 | Word length in bits |
| cfg_cpol_i | input | 1 | Clock idle level |
| cfg_cdly_i | input | 1 | Clock delay enable (1 = sample on leading edge) |
| cfg_lsb_i | input | 1 | LSB first when 1 |
| cfg_div_i | input | 2 | Pre-divider code |
| cfg_brg_i | input | 6 | Baud divider code |
| start_i | input | 1 | Master start strobe |
| tx_push_i | input | 1 | Push a word into the TX FIFO |
| tx_last_i | input | 1 | Tag the pushed word as the last of the transfer |
| tx_data_i | input | 24 | Right-aligned transmit word |
| tx_full_o | output | 1 | TX FIFO full |
| rx_pop_i | input | 1 | Pop the RX FIFO head |
| rx_data_o | output | 24 | RX FIFO head word |
| rx_empty_o | output | 1 | RX FIFO empty |
| rx_clr_i | input | 1 | Empty the RX FIFO |
| tx_clr_i | input | 1 | Empty the TX FIFO |
| clr_busy_o | output | 2 | FIFO clear in progress {tx, rx} |
| evt_clr_i | input | 9 | Write-one-to-clear event bits |
| evt_msk_i | input | 9 | Event mask, 1 blocks the interrupt |
| mm_err_i | input | 1 | Multi-master error indication |
| evt_o | output | 9 | Pending events |
| irq_o | output | 1 | Interrupt |
| ready_o | output | 1 | Device ready |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest conditions to reach are a pause in the middle of a transfer and a receive overflow, because a host that keeps up never produces either. The stimulus creates the pause by queuing only untagged words and letting the FIFO drain. It waits for the underflow event, confirms the clock stays parked, then supplies the tagged word and restarts. For the overflow, the receive monitor is switched off while nine words are shifted, and the eight words that were kept are then drained by hand and checked against their order.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WMAX  = 24;
  localparam int LW    = $clog2(WMAX + 1);
  localparam int NEV   = 9;
  localparam int EV_MD = 0;
  localparam int EV_SD = 1;
  localparam int EV_MM = 2;
  localparam int EV_TU = 3;
  localparam int EV_TO = 4;
  localparam int EV_TR = 5;
  localparam int EV_RU = 6;
  localparam int EV_RO = 7;
  localparam int EV_RR = 8;

  typedef struct packed {
    logic [LW-1:0] len;
    logic          cpol;
    logic          cdly;
    logic          lsb;
    logic [1:0]    div;
    logic [5:0]    brg;
  } cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAUSE} st_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign full_o  = cnt_q == (AW+1)'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int CW = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] div_i,
  input  logic [5:0] brg_i,
  output logic       tick_o
);
  logic [CW-1:0] cnt_q, half;

  // half period in main clocks: (2 << div) * (brg + 1)
  assign half   = (CW'(2) << div_i) * (CW'(brg_i) + CW'(1));
  assign tick_o = run_i && (cnt_q == half - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cfg_t            cfg_i,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic            tx_empty_i,
  input  logic [WMAX:0]   tx_ent_i,
  output logic            tx_pop_o,
  output logic            rx_push_o,
  output logic [WMAX-1:0] rx_word_o,
  output logic            tu_o,
  output logic            md_o,
  output logic            active_o,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic            miso_i
);
  st_e st_q;
  logic [WMAX-1:0] word_q, rx_q, rx_nx;
  logic [LW-1:0]   k_q, pos;
  logic last_q, half_q, sclk_q, mosi_q;
  logic run, done, idle_start, load;

  function automatic logic bit_at(input logic [WMAX-1:0] w, input logic [LW-1:0] i,
                                  input logic [LW-1:0] len, input logic lsb);
    logic [LW-1:0] p;
    if (i >= len) return 1'b0;
    p = lsb ? i : LW'(len - LW'(1) - i);
    return w[p];
  endfunction

  assign run        = st_q == S_RUN;
  assign pos        = cfg_i.lsb ? k_q : LW'(cfg_i.len - LW'(1) - k_q);
  assign done       = run && tick_i && half_q && (k_q == LW'(cfg_i.len - LW'(1)));
  assign idle_start = !run && start_i;
  assign load       = (idle_start && !tx_empty_i) || (done && !last_q && !tx_empty_i);

  always_comb begin
    rx_nx = rx_q;
    if (!cfg_i.cdly) rx_nx[pos] = miso_i;
  end

  assign tx_pop_o  = load;
  assign rx_push_o = done;
  assign rx_word_o = rx_nx;
  assign tu_o      = (idle_start && tx_empty_i) || (done && !last_q && tx_empty_i);
  assign md_o      = done && last_q;
  assign active_o  = run;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; word_q <= '0; rx_q <= '0; k_q <= '0;
      last_q <= 1'b0; half_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
    end else begin
      if (run && tick_i) begin
        half_q <= !half_q;
        if (!half_q) begin               // leading edge
          sclk_q <= !cfg_i.cpol;
          if (cfg_i.cdly) rx_q[pos] <= miso_i;
          else            mosi_q <= bit_at(word_q, k_q, cfg_i.len, cfg_i.lsb);
        end else begin                   // trailing edge
          sclk_q <= cfg_i.cpol;
          k_q    <= k_q + LW'(1);
          rx_q   <= rx_nx;
          if (cfg_i.cdly) mosi_q <= bit_at(word_q, k_q + LW'(1), cfg_i.len, cfg_i.lsb);
        end
      end else if (!run) begin
        sclk_q <= cfg_i.cpol;
      end
      if (done)                            st_q <= last_q ? S_IDLE : S_PAUSE;
      else if (idle_start && tx_empty_i)   st_q <= S_PAUSE;
      if (load) begin
        st_q   <= S_RUN;
        word_q <= tx_ent_i[WMAX-1:0];
        last_q <= tx_ent_i[WMAX];
        k_q    <= '0;
        half_q <= 1'b0;
        rx_q   <= '0;
        if (cfg_i.cdly) mosi_q <= bit_at(tx_ent_i[WMAX-1:0], '0, cfg_i.len, cfg_i.lsb);
      end
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [LW-1:0]   cfg_len_i,
  input  logic            cfg_cpol_i,
  input  logic            cfg_cdly_i,
  input  logic            cfg_lsb_i,
  input  logic [1:0]      cfg_div_i,
  input  logic [5:0]      cfg_brg_i,
  input  logic            start_i,
  input  logic            tx_push_i,
  input  logic            tx_last_i,
  input  logic [WMAX-1:0] tx_data_i,
  output logic            tx_full_o,
  input  logic            rx_pop_i,
  output logic [WMAX-1:0] rx_data_o,
  output logic            rx_empty_o,
  input  logic            rx_clr_i,
  input  logic            tx_clr_i,
  output logic [1:0]      clr_busy_o,
  input  logic [NEV-1:0]  evt_clr_i,
  input  logic [NEV-1:0]  evt_msk_i,
  input  logic            mm_err_i,
  output logic [NEV-1:0]  evt_o,
  output logic            irq_o,
  output logic            ready_o,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic            miso_i
);
  cfg_t cfg_q;
  logic ready_q;
  logic [1:0] clr_q;
  logic [NEV-1:0] evt_q, ev_set;
  logic [WMAX:0] tx_ent;
  logic [WMAX-1:0] rx_word;
  logic tx_empty, tx_pop, rx_push, rx_full, tu, md, tick, shift_active;
  logic [LW-1:0] len_sat;

  assign len_sat = (cfg_len_i < LW'(4)) ? LW'(4) :
                   (cfg_len_i > LW'(WMAX)) ? LW'(WMAX) : cfg_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '{len: LW'(8), cpol: 1'b0, cdly: 1'b0, lsb: 1'b0, div: 2'd0, brg: 6'd0};
      ready_q <= 1'b0;
      clr_q   <= '0;
      evt_q   <= '0;
    end else begin
      if (!en_i) cfg_q <= '{len: len_sat, cpol: cfg_cpol_i, cdly: cfg_cdly_i,
                            lsb: cfg_lsb_i, div: cfg_div_i, brg: cfg_brg_i};
      ready_q <= en_i;
      clr_q   <= {tx_clr_i, rx_clr_i};
      evt_q   <= (evt_q & ~evt_clr_i) | ev_set;
    end
  end

  always_comb begin
    ev_set        = '0;
    ev_set[EV_MD] = md;
    ev_set[EV_MM] = mm_err_i;
    ev_set[EV_TU] = tu;
    ev_set[EV_TO] = tx_push_i && tx_full_o;
    ev_set[EV_TR] = tx_pop;
    ev_set[EV_RU] = rx_pop_i && rx_empty_o;
    ev_set[EV_RO] = rx_push && rx_full;
    ev_set[EV_RR] = rx_push && !rx_full;
  end

  spim_fifo #(.W(WMAX + 1), .DEPTH(DEPTH)) u_txf (
    .clk_i, .rst_ni, .clr_i(clr_q[1]), .push_i(tx_push_i),
    .din_i({tx_last_i, tx_data_i}), .pop_i(tx_pop), .dout_o(tx_ent),
    .full_o(tx_full_o), .empty_o(tx_empty));

  spim_fifo #(.W(WMAX), .DEPTH(DEPTH)) u_rxf (
    .clk_i, .rst_ni, .clr_i(clr_q[0]), .push_i(rx_push),
    .din_i(rx_word), .pop_i(rx_pop_i), .dout_o(rx_data_o),
    .full_o(rx_full), .empty_o(rx_empty_o));

  spim_clkdiv u_div (
    .clk_i, .rst_ni, .run_i(shift_active), .div_i(cfg_q.div), .brg_i(cfg_q.brg),
    .tick_o(tick));

  spim_shift u_shift (
    .clk_i, .rst_ni, .cfg_i(cfg_q), .tick_i(tick), .start_i(start_i && ready_q),
    .tx_empty_i(tx_empty), .tx_ent_i(tx_ent), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_word_o(rx_word), .tu_o(tu), .md_o(md),
    .active_o(shift_active), .sclk_o, .mosi_o, .miso_i);

  assign clr_busy_o = clr_q;
  assign evt_o      = evt_q;
  assign irq_o      = |(evt_q & ~evt_msk_i);
  assign ready_o    = ready_q;
endmodule

// File: rtl/spim_engine_chk.sv
module spim_engine_chk
  import spim_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           ready_o,
  input logic           tx_push_i,
  input logic           tx_full_o,
  input logic           tx_clr_i,
  input logic [1:0]     clr_busy_o,
  input logic [NEV-1:0] evt_o,
  input logic           rx_push,
  input logic           rx_full,
  input logic           active,
  input logic           cpol,
  input logic           sclk_o
);
  assert_ready_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ready_o);

  assert_sclk_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !$past(active)) |-> sclk_o == $past(cpol));

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[EV_MD]) |-> !active);

  assert_tx_ovf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && tx_full_o) |=> evt_o[EV_TO]);

  assert_rx_ovf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full) |=> evt_o[EV_RO]);

  assert_tx_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_busy_o[1] && !tx_clr_i) |=> (!clr_busy_o[1] && !tx_full_o));
endmodule

bind spim_engine spim_engine_chk u_chk (
  .clk_i, .rst_ni, .en_i, .ready_o, .tx_push_i, .tx_full_o, .tx_clr_i,
  .clr_busy_o, .evt_o, .rx_push(rx_push), .rx_full(rx_full),
  .active(shift_active), .cpol(cfg_q.cpol), .sclk_o);

// File: tb/spim_engine_tb.sv
module spim_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk_i = 0, rst_ni = 0, en_i = 0;
  logic [4:0] cfg_len_i = 5'd8;
  logic cfg_cpol_i = 0, cfg_cdly_i = 0, cfg_lsb_i = 0;
  logic [1:0] cfg_div_i = 0;
  logic [5:0] cfg_brg_i = 0;
  logic start_i = 0, tx_push_i = 0, tx_last_i = 0;
  logic [23:0] tx_data_i = 0;
  logic tx_full_o, rx_empty_o, irq_o, ready_o, sclk_o, mosi_o;
  logic [23:0] rx_data_o;
  logic rx_clr_i = 0, tx_clr_i = 0, mm_err_i = 0, tb_pop = 0, mon_pop = 0;
  logic [1:0] clr_busy_o;
  logic [8:0] evt_clr_i = 0, evt_msk_i = '1, evt_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spim_engine u_dut (
    .clk_i, .rst_ni, .en_i, .cfg_len_i, .cfg_cpol_i, .cfg_cdly_i, .cfg_lsb_i,
    .cfg_div_i, .cfg_brg_i, .start_i, .tx_push_i, .tx_last_i, .tx_data_i,
    .tx_full_o, .rx_pop_i(tb_pop | mon_pop), .rx_data_o, .rx_empty_o, .rx_clr_i,
    .tx_clr_i, .clr_busy_o, .evt_clr_i, .evt_msk_i, .mm_err_i, .evt_o, .irq_o,
    .ready_o, .sclk_o, .mosi_o, .miso_i(mosi_o));

  int n_chk = 0, n_fail = 0;
  bit finished = 0, mon_en = 1;
  int t_len = 8; bit t_cpol = 0, t_cdly = 0, t_lsb = 0;
  int ser_gen = 0;
  logic [23:0] rx_exp[$], ser_exp[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] lmask(input int len);
    return (24'h1 << len) - 24'h1;
  endfunction

  // scoreboard monitor: pops received words
  always @(negedge clk_i) begin
    if (mon_pop) mon_pop = 0;
    else if (mon_en && !rx_empty_o) begin
      if (rx_exp.size() == 0) chk(0, "R3 unexpected rx word", rx_data_o, 0);
      else begin
        logic [23:0] e;
        e = rx_exp.pop_front();
        chk(rx_data_o == e, "R3 rx word", rx_data_o, e);
      end
      mon_pop = 1;
    end
  end

  // serial monitor: rebuilds words from the line at the sampling edge
  int seen_gen = 0, ser_cnt = 0;
  logic [23:0] ser_w = 0;
  logic prev_sclk = 0;
  always @(negedge clk_i) begin
    if (seen_gen != ser_gen) begin
      seen_gen = ser_gen; ser_cnt = 0; ser_w = 0; prev_sclk = sclk_o;
    end else if (sclk_o !== prev_sclk) begin
      prev_sclk = sclk_o;
      if (t_cdly ? (sclk_o != t_cpol) : (sclk_o == t_cpol)) begin
        if (t_lsb) ser_w[ser_cnt] = mosi_o;
        else       ser_w[t_len-1-ser_cnt] = mosi_o;
        ser_cnt++;
        if (ser_cnt == t_len) begin
          if (ser_exp.size() == 0) chk(0, "R4 unexpected serial word", ser_w, 0);
          else begin
            logic [23:0] e;
            e = ser_exp.pop_front();
            chk(ser_w == e, "R4/R5 serial order and phase", ser_w, e);
          end
          ser_cnt = 0; ser_w = 0;
        end
      end
    end
  end

  task automatic configure(input int len, input bit cpol, input bit cdly, input bit lsb,
                           input int div, input int brg);
    @(negedge clk_i) en_i = 0;
    @(negedge clk_i);
    cfg_len_i = 5'(len); cfg_cpol_i = cpol; cfg_cdly_i = cdly; cfg_lsb_i = lsb;
    cfg_div_i = 2'(div); cfg_brg_i = 6'(brg);
    repeat (3) @(negedge clk_i);
    t_len = len; t_cpol = cpol; t_cdly = cdly; t_lsb = lsb;
    en_i = 1;
    repeat (2) @(negedge clk_i);
    ser_gen++;
    @(negedge clk_i);
  endtask

  task automatic push(input logic [23:0] d, input bit last, input bit rx_e, input bit ser_e);
    @(negedge clk_i) tx_data_i = d; tx_last_i = last; tx_push_i = 1;
    @(negedge clk_i) tx_push_i = 0; tx_last_i = 0;
    if (rx_e)  rx_exp.push_back(d & lmask(t_len));
    if (ser_e) ser_exp.push_back(d & lmask(t_len));
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1;
    @(negedge clk_i) start_i = 0;
  endtask

  task automatic clr_evt();
    @(negedge clk_i) evt_clr_i = '1;
    @(negedge clk_i) evt_clr_i = '0;
  endtask

  task automatic wait_evt(input int b, input string req);
    int n = 0;
    while (!evt_o[b] && n < 20000) begin @(negedge clk_i); n++; end
    chk(evt_o[b], req, evt_o[b], 1);
  endtask

  task automatic drained(input string req);
    repeat (6) @(negedge clk_i);
    chk(rx_exp.size() == 0 && ser_exp.size() == 0, req, rx_exp.size() + ser_exp.size(), 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(evt_o == 0 && irq_o == 0, "R1 events/irq", {evt_o, irq_o}, 0);
    chk(rx_empty_o && !tx_full_o, "R1 fifo flags", {rx_empty_o, tx_full_o}, 2);
    chk(!ready_o && !sclk_o && clr_busy_o == 0, "R1 ready/sclk/clr",
        {ready_o, sclk_o, clr_busy_o}, 0);

    // R2 ready, R3/R4/R5 mode 0 msb first
    configure(8, 0, 1, 0, 0, 0);
    chk(ready_o, "R2 ready after enable", ready_o, 1);
    clr_evt();
    push(24'hA5, 0, 1, 1); push(24'h3C, 0, 1, 1); push(24'h81, 1, 1, 1);
    pulse_start();
    wait_evt(0, "R7 done event");
    @(negedge clk_i);
    chk(sclk_o == 0, "R7 clock idle after last", sclk_o, 0);
    drained("R3 mode cpol0 cdly1 msb");

    // R3 right alignment, R4 lsb first, R5 cpol1 cdly0
    configure(12, 1, 0, 1, 0, 1);
    chk(sclk_o == 1, "R5 idle level cpol1", sclk_o, 1);
    clr_evt();
    push(24'hABC, 0, 1, 1); push(24'hF0123, 0, 1, 1); push(24'hFFF, 1, 1, 1);
    pulse_start();
    wait_evt(0, "R7 done event len12");
    drained("R3 R4 len12 lsb cpol1 cdly0");

    configure(4, 0, 0, 0, 0, 0);
    clr_evt();
    push(24'h9, 0, 1, 1); push(24'hF6, 1, 1, 1);
    pulse_start();
    wait_evt(0, "R7 done event len4");
    drained("R3 len4 minimum");

    configure(24, 1, 1, 1, 0, 0);
    clr_evt();
    push(24'hABCDEF, 0, 1, 1); push(24'h800001, 1, 1, 1);
    pulse_start();
    wait_evt(0, "R7 done event len24");
    drained("R3 len24 maximum");

    // R6 half period (2<<1)*(2+1)=12
    configure(4, 0, 1, 0, 1, 2);
    clr_evt();
    push(24'h5, 1, 1, 1);
    pulse_start();
    begin
      logic p; int n = 0;
      p = sclk_o;
      while (sclk_o == p && n < 1000) begin @(negedge clk_i); n++; end
      p = sclk_o; n = 0;
      while (sclk_o == p && n < 1000) begin @(negedge clk_i); n++; end
      chk(n == 12, "R6 half period", n, 12);
    end
    wait_evt(0, "R7 done event slow clock");
    drained("R6 data at slow clock");

    // R2 config changes while enabled are ignored
    configure(8, 0, 0, 0, 0, 0);
    cfg_len_i = 5'd16; cfg_lsb_i = 1; cfg_cpol_i = 1;
    clr_evt();
    push(24'h1234C3, 1, 1, 1);
    pulse_start();
    wait_evt(0, "R2 done with held config");
    drained("R2 config held while enabled");

    // R8 underflow pause and resume
    configure(8, 1, 0, 0, 0, 0);
    clr_evt();
    push(24'h11, 0, 1, 1); push(24'h22, 0, 1, 1);
    pulse_start();
    wait_evt(3, "R8 tx underflow event");
    begin
      int tg = 0;
      repeat (40) begin @(negedge clk_i); if (sclk_o != 1) tg++; end
      chk(tg == 0 && !evt_o[0], "R8 paused at idle", tg, 0);
    end
    push(24'h33, 1, 1, 1);
    pulse_start();
    wait_evt(0, "R8 resumed to done");
    drained("R8 words across pause");

    // R10 mask and interrupt, R9 clear and mm event
    evt_msk_i = '1;
    @(negedge clk_i);
    chk(!irq_o, "R10 masked irq", irq_o, 0);
    evt_msk_i = 9'h1FE;
    @(negedge clk_i);
    chk(irq_o, "R10 unmasked irq", irq_o, 1);
    clr_evt();
    chk(evt_o == 0 && !irq_o, "R9 write-one clear", evt_o, 0);
    @(negedge clk_i) mm_err_i = 1;
    @(negedge clk_i) mm_err_i = 0;
    chk(evt_o == 9'h004, "R9 multi-master bit 2", evt_o, 9'h004);
    evt_msk_i = '1;
    clr_evt();

    // R11 tx overflow, R13 full flag, R12 tx clear
    mon_en = 0;
    for (int i = 0; i < 8; i++) push(24'h40 + 24'(i), 0, 0, 0);
    chk(tx_full_o, "R13 tx full", tx_full_o, 1);
    push(24'h77, 1, 0, 0);
    chk(evt_o[4], "R11 tx overflow bit 4", evt_o[4], 1);
    @(negedge clk_i) tx_clr_i = 1;
    @(negedge clk_i) tx_clr_i = 0;
    chk(clr_busy_o == 2'b10, "R12 tx clear busy", clr_busy_o, 2);
    @(negedge clk_i);
    chk(clr_busy_o == 0 && !tx_full_o, "R12 tx cleared", {clr_busy_o, tx_full_o}, 0);
    clr_evt();
    pulse_start();
    @(negedge clk_i);
    chk(evt_o[3] && sclk_o == 1, "R8 start on empty fifo", {evt_o[3], sclk_o}, 3);

    // R11 rx overflow and underflow
    clr_evt();
    for (int i = 0; i < 8; i++) push(24'h50 + 24'(i), 0, 0, 1);
    pulse_start();
    push(24'h5F, 1, 0, 1);
    wait_evt(0, "R7 done before overflow check");
    chk(evt_o[7], "R11 rx overflow bit 7", evt_o[7], 1);
    for (int i = 0; i < 8; i++) begin
      chk(rx_data_o == 24'h50 + 24'(i), "R11 kept rx words", rx_data_o, 24'h50 + i);
      @(negedge clk_i) tb_pop = 1;
      @(negedge clk_i) tb_pop = 0;
    end
    chk(rx_empty_o, "R13 rx empty after drain", rx_empty_o, 1);
    @(negedge clk_i) tb_pop = 1;
    @(negedge clk_i) tb_pop = 0;
    chk(evt_o[6], "R11 rx underflow bit 6", evt_o[6], 1);
    drained("R4 serial during overflow");

    // R12 rx clear
    clr_evt();
    push(24'h66, 1, 0, 1);
    pulse_start();
    wait_evt(0, "R7 done before rx clear");
    @(negedge clk_i);
    chk(!rx_empty_o, "R13 rx not empty", rx_empty_o, 0);
    @(negedge clk_i) rx_clr_i = 1;
    @(negedge clk_i) rx_clr_i = 0;
    chk(clr_busy_o == 2'b01, "R12 rx clear busy", clr_busy_o, 1);
    @(negedge clk_i);
    chk(clr_busy_o == 0 && rx_empty_o, "R12 rx cleared", {clr_busy_o, rx_empty_o}, 1);

    // R2 ready falls
    @(negedge clk_i) en_i = 0;
    @(negedge clk_i);
    chk(!ready_o, "R2 ready drops", ready_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule